// File: doc/BRIEF.md
# NaN Payload Format Converter

This block moves a NaN from one IEEE binary interchange width to another (half, single or double precision) and keeps its sign and as much of its payload as the destination can hold. The source fraction is first widened into a 64-bit canonical significand, left-aligned so that the most significant fraction bit always sits at bit 63. The destination fraction is then cut from the top of that field. Widening therefore pads the payload with zeros at the bottom, and narrowing drops its low bits.

If narrowing drops every set bit, the result would have a zero fraction, which would encode an infinity. In that case the block substitutes the destination's default NaN. A default-NaN mode forces that pattern for every input. A mode bit selects which polarity of the leading fraction bit marks a signaling NaN. That bit also decides which default patterns are used. The invalid flag rises whenever the source is a signaling NaN, even when the value is replaced.

The result and the flag are registered, with one cycle of latency and a synchronous active-high reset. A caller is expected to present only NaN inputs. A NaN is never silenced on the way through.

Top module: `nanconv_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `dst_val` is 0 and `invalid` is 0.
- R2: Widening keeps the sign and places the source fraction at the top of the destination fraction, with zeros below it. The exponent field is all ones. For example, half 0x7E01 to double gives 0x7FF8040000000000.
- R3: Narrowing keeps the sign and the most significant destination-width bits of the source fraction. For example, double 0xFFFABC0000000000 to half gives 0xFEAF.
- R4: If the fraction kept after narrowing is zero, the output is the destination default NaN and never an infinity.
- R5: When `dflt_nan_en` is 1, the output is the destination default NaN whatever the source is.
- R6: With `snan_one` = 0, a source is signaling when its exponent field is all ones, the fraction MSB is 0 and the other fraction bits are nonzero. `invalid` is then 1, and it stays 1 even when R4 or R5 replaces the value.
- R7: With `snan_one` = 1, a source is signaling when its exponent field is all ones and the fraction MSB is 1. The default NaNs are then 0x7DFF, 0x7FBFFFFF and 0x7FF7FFFFFFFFFFFF. With `snan_one` = 0 they are 0x7E00, 0x7FC00000 and 0x7FF8000000000000.
- R8: The format codes are 0 for half, 1 for single and 2 for double, and code 3 acts as double. Bits of `src_val` above the source width are ignored. Bits of `dst_val` above the destination width are 0.
- R9: `dst_val` and `invalid` reflect the inputs sampled at the previous rising clock edge.
- R10: Converting to the same format returns the source NaN bit for bit, without silencing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 64 | Source NaN, right-aligned |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| snan_one | input | 1 | 1: a set fraction MSB marks a signaling NaN |
| dflt_nan_en | input | 1 | Force the default NaN on the output |
| dst_val | output | 64 | Destination NaN, zero-extended |
| invalid | output | 1 | Source was a signaling NaN |

## Verification
Two functions can act in the same cycle: raising the invalid flag and replacing the value with a default NaN. Replacement can come from default-NaN mode or from a payload truncated to zero. The bench provokes both cases with signaling sources whose payload lies entirely in the low bits, narrowed to half, and with signaling sources converted while default mode is on. A behavioural model predicts both outputs for every cycle. A correct result needs the flag high while the value equals the default pattern, so a design that lets one function suppress the other shows a mismatch on one of the two outputs.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;
  localparam int CANON_W = 64;
  localparam int VAL_W   = 64;
  localparam int NUM_FMT = 3;
  localparam int MAX_FW  = 52;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_ALIAS  = 2'd3
  } fmt_e;

  function automatic int frac_bits(int lane);
    case (lane)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic int exp_bits(int lane);
    case (lane)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] dflt_pattern(int lane, logic s1);
    case (lane)
      0:       return s1 ? 64'h7DFF : 64'h7E00;
      1:       return s1 ? 64'h7FBF_FFFF : 64'h7FC0_0000;
      default: return s1 ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/nanconv_unpack.sv
module nanconv_unpack
  import nanconv_pkg::*;
#(
  parameter int CW = CANON_W
) (
  input  logic [VAL_W-1:0] val_i,
  input  logic [1:0]       fmt_i,
  input  logic             snan_one_i,
  output logic             sign_o,
  output logic [CW-1:0]    canon_o,
  output logic             snan_o
);
  logic [NUM_FMT-1:0] lane_sign;
  logic [NUM_FMT-1:0] lane_snan;
  logic [CW-1:0]      lane_canon [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int FW = frac_bits(g);
    localparam int EW = exp_bits(g);
    localparam int TW = 1 + EW + FW;
    logic [EW-1:0] ex;
    logic [FW-1:0] fr;
    logic          exp_ones;
    logic          lead;
    logic          rest_nz;

    assign ex       = val_i[TW-2:FW];
    assign fr       = val_i[FW-1:0];
    assign exp_ones = &ex;
    assign lead     = fr[FW-1];
    assign rest_nz  = |fr[FW-2:0];
    assign lane_sign[g]  = val_i[TW-1];
    assign lane_canon[g] = {fr, {(CW-FW){1'b0}}};
    assign lane_snan[g]  = exp_ones & (snan_one_i ? lead : (~lead & rest_nz));
  end

  always_comb begin
    case (fmt_i)
      FMT_HALF: begin
        sign_o = lane_sign[0]; canon_o = lane_canon[0]; snan_o = lane_snan[0];
      end
      FMT_SINGLE: begin
        sign_o = lane_sign[1]; canon_o = lane_canon[1]; snan_o = lane_snan[1];
      end
      default: begin
        sign_o = lane_sign[2]; canon_o = lane_canon[2]; snan_o = lane_snan[2];
      end
    endcase
  end
endmodule

// File: rtl/nanconv_pack.sv
module nanconv_pack
  import nanconv_pkg::*;
#(
  parameter int CW = CANON_W
) (
  input  logic             sign_i,
  input  logic [CW-1:0]    canon_i,
  input  logic [1:0]       fmt_i,
  input  logic             snan_one_i,
  input  logic             dflt_en_i,
  output logic [VAL_W-1:0] val_o
);
  logic [VAL_W-1:0] lane_val [NUM_FMT];
  logic             unused_low_bits;

  assign unused_low_bits = ^canon_i[CW-MAX_FW-1:0];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int FW = frac_bits(g);
    localparam int EW = exp_bits(g);
    localparam int TW = 1 + EW + FW;
    logic [FW-1:0]    fr;
    logic [TW-1:0]    built;
    logic [VAL_W-1:0] dflt;

    assign fr    = canon_i[CW-1 -: FW];
    assign built = {sign_i, {EW{1'b1}}, fr};
    assign dflt  = dflt_pattern(g, snan_one_i);
    assign lane_val[g] = (dflt_en_i || (fr == '0)) ? dflt : VAL_W'(built);
  end

  always_comb begin
    case (fmt_i)
      FMT_HALF:   val_o = lane_val[0];
      FMT_SINGLE: val_o = lane_val[1];
      default:    val_o = lane_val[2];
    endcase
  end
endmodule

// File: rtl/nanconv_top.sv
module nanconv_top
  import nanconv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] src_val,
  input  logic [1:0]       src_fmt,
  input  logic [1:0]       dst_fmt,
  input  logic             snan_one,
  input  logic             dflt_nan_en,
  output logic [VAL_W-1:0] dst_val,
  output logic             invalid
);
  logic               cn_sign;
  logic [CANON_W-1:0] cn_sig;
  logic               cn_snan;
  logic [VAL_W-1:0]   packed_val;

  nanconv_unpack #(.CW(CANON_W)) unpack_i (
    .val_i      (src_val),
    .fmt_i      (src_fmt),
    .snan_one_i (snan_one),
    .sign_o     (cn_sign),
    .canon_o    (cn_sig),
    .snan_o     (cn_snan)
  );

  nanconv_pack #(.CW(CANON_W)) pack_i (
    .sign_i     (cn_sign),
    .canon_i    (cn_sig),
    .fmt_i      (dst_fmt),
    .snan_one_i (snan_one),
    .dflt_en_i  (dflt_nan_en),
    .val_o      (packed_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_val <= '0;
      invalid <= 1'b0;
    end else begin
      dst_val <= packed_val;
      invalid <= cn_snan;
    end
  end
endmodule

// File: rtl/nanconv_chk.sv
module nanconv_chk (
  input logic        clk,
  input logic        rst,
  input logic [63:0] src_val,
  input logic [1:0]  src_fmt,
  input logic [1:0]  dst_fmt,
  input logic        snan_one,
  input logic        dflt_nan_en,
  input logic [63:0] dst_val,
  input logic        invalid
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dst_val == 64'd0 && !invalid)); // R1

  AST_HALF_NEVER_INF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dst_fmt) == 2'd0) |->
      (dst_val[14:10] == 5'h1F && dst_val[9:0] != 10'd0)); // R4

  AST_DFLT_FORCED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dflt_nan_en) && !$past(snan_one) && $past(dst_fmt) == 2'd1)
      |-> (dst_val == 64'h7FC0_0000)); // R5

  AST_SINGLE_SNAN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(snan_one) && $past(src_fmt) == 2'd1 &&
     $past(src_val[30:22]) == 9'h1FE && $past(src_val[21:0]) != 22'd0) |-> invalid); // R6

  AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dst_fmt) == 2'd0) |-> (dst_val[63:16] == 48'd0)); // R8

  AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dflt_nan_en) && $past(src_fmt) == 2'd1 && $past(dst_fmt) == 2'd1 &&
     $past(src_val[30:23]) == 8'hFF && $past(src_val[22:0]) != 23'd0)
      |-> (dst_val == {32'd0, $past(src_val[31:0])})); // R10
endmodule

bind nanconv_top nanconv_chk chk_i (.*);

// File: tb/nanconv_tb.sv
`timescale 1ns/1ps
module nanconv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_val = '0;
  logic [1:0]  src_fmt = '0;
  logic [1:0]  dst_fmt = '0;
  logic        snan_one = 1'b0;
  logic        dflt_nan_en = 1'b0;
  logic [63:0] dst_val;
  logic        invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nanconv_top dut_i (
    .clk(clk), .rst(rst), .src_val(src_val), .src_fmt(src_fmt), .dst_fmt(dst_fmt),
    .snan_one(snan_one), .dflt_nan_en(dflt_nan_en), .dst_val(dst_val), .invalid(invalid)
  );

  function automatic int fw_of(logic [1:0] f);
    return (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
  endfunction

  function automatic int ew_of(logic [1:0] f);
    return (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
  endfunction

  function automatic logic [64:0] model(logic [63:0] v, logic [1:0] sf, logic [1:0] df,
                                        logic s1, logic dm);
    int sfw = fw_of(sf);
    int sew = ew_of(sf);
    int dfw = fw_of(df);
    int dew = ew_of(df);
    logic [63:0] frac = v & ((64'd1 << sfw) - 1);
    logic [63:0] ex   = (v >> sfw) & ((64'd1 << sew) - 1);
    logic        sg   = v[sfw + sew];
    logic        lead = frac[sfw - 1];
    logic        ones = (ex == ((64'd1 << sew) - 1));
    logic        sig  = ones && (s1 ? lead : (!lead && frac != 0));
    logic [63:0] nf   = (dfw >= sfw) ? (frac << (dfw - sfw)) : (frac >> (sfw - dfw));
    logic [63:0] dv;
    if (df == 2'd0)      dv = s1 ? 64'h7DFF : 64'h7E00;
    else if (df == 2'd1) dv = s1 ? 64'h7FBF_FFFF : 64'h7FC0_0000;
    else                 dv = s1 ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000;
    if (dm || nf == 0) return {sig, dv};
    return {sig, (64'(sg) << (dfw + dew)) | (((64'd1 << dew) - 1) << dfw) | nf};
  endfunction

  task automatic check(string req, logic [63:0] got_v, logic got_i,
                       logic [63:0] exp_v, logic exp_i);
    n_chk++;
    if (got_v !== exp_v || got_i !== exp_i) begin
      n_bad++;
      $display("FAIL %s: got val=%h inv=%b expected val=%h inv=%b", req, got_v, got_i, exp_v, exp_i);
    end
  endtask

  task automatic apply(string req, logic [63:0] v, logic [1:0] sf, logic [1:0] df,
                       logic s1, logic dm, logic [63:0] exp_v, logic exp_i);
    logic [64:0] m;
    @(negedge clk);
    src_val = v; src_fmt = sf; dst_fmt = df; snan_one = s1; dflt_nan_en = dm;
    m = model(v, sf, df, s1, dm);
    @(negedge clk);
    check(req, dst_val, invalid, exp_v, exp_i);
    check({req, " model"}, dst_val, invalid, m[63:0], m[64]);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got val=%h inv=%b expected completion", dst_val, invalid);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [64:0] exp_q;
    repeat (3) @(negedge clk);
    check("R1 in reset", dst_val, invalid, 64'd0, 1'b0);
    src_val = 64'h7FF0_0000_0000_0001;
    src_fmt = 2'd2; dst_fmt = 2'd2;
    @(negedge clk);
    check("R1 held", dst_val, invalid, 64'd0, 1'b0);
    rst = 1'b0;

    apply("R2 half to double", 64'h7E01, 2'd0, 2'd2, 0, 0, 64'h7FF8_0400_0000_0000, 0);
    apply("R2 R6 snan half to single", 64'hFD00, 2'd0, 2'd1, 0, 0, 64'hFFA0_0000, 1);
    apply("R3 double to half", 64'hFFFA_BC00_0000_0000, 2'd2, 2'd0, 0, 0, 64'hFEAF, 0);
    apply("R4 R6 double low payload", 64'h7FF0_0000_0000_0001, 2'd2, 2'd0, 0, 0, 64'h7E00, 1);
    apply("R4 single low payload", 64'h7F80_0001, 2'd1, 2'd0, 0, 0, 64'h7E00, 1);
    apply("R5 default mode", 64'hFFC1_2345, 2'd1, 2'd2, 0, 1, 64'h7FF8_0000_0000_0000, 0);
    apply("R5 R6 default with snan", 64'h7F81_2345, 2'd1, 2'd0, 0, 1, 64'h7E00, 1);
    apply("R7 lead set signals", 64'h7FC0_0001, 2'd1, 2'd1, 1, 0, 64'h7FC0_0001, 1);
    apply("R7 alt default", 64'h7F80_0001, 2'd1, 2'd0, 1, 0, 64'h7DFF, 0);
    apply("R7 alt default double", 64'h7FC0_0000, 2'd1, 2'd3, 1, 1, 64'h7FF7_FFFF_FFFF_FFFF, 1);
    apply("R8 code 3 source", 64'h7FF4_0000_0000_0000, 2'd3, 2'd1, 0, 0, 64'h7FA0_0000, 1);
    apply("R8 upper src ignored", 64'hDEAD_BEEF_0000_7E01, 2'd0, 2'd3, 0, 0, 64'h7FF8_0400_0000_0000, 0);
    apply("R10 same format", 64'h7F81_2345, 2'd1, 2'd1, 0, 0, 64'h7F81_2345, 1);

    // R9: back-to-back inputs, each output compared one edge after it was sampled
    @(negedge clk);
    exp_q = 'x;
    for (int i = 0; i < 400; i++) begin
      int sf = $urandom_range(0, 3);
      int df = $urandom_range(0, 3);
      int fw = fw_of(2'(sf));
      int ew = ew_of(2'(sf));
      logic [63:0] fr = {$urandom, $urandom};
      logic [63:0] v;
      fr = fr & ((64'd1 << fw) - 1);
      if ((i % 5) == 0) fr = fr & 64'hFF;
      if (fr == 0) fr = 64'd1;
      v = {$urandom, $urandom};
      v = (v & ~((64'd1 << (fw + ew)) - 1)) | (((64'd1 << ew) - 1) << fw) | fr;
      src_val = v; src_fmt = 2'(sf); dst_fmt = 2'(df);
      snan_one = 1'($urandom_range(0, 1));
      dflt_nan_en = ($urandom_range(0, 7) == 0);
      if (i > 0) check("R9 R2 R3 R4 stream", dst_val, invalid, exp_q[63:0], exp_q[64]);
      exp_q = model(src_val, src_fmt, dst_fmt, snan_one, dflt_nan_en);
      @(negedge clk);
    end
    check("R9 R2 R3 R4 stream last", dst_val, invalid, exp_q[63:0], exp_q[64]);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule